// File: doc/BRIEF.md
# Trimmed 256 Hz / 1 Hz Clock Divider

This block runs on a 32.768 kHz source clock and produces a regulated 256 Hz tick. It divides that tick by 256 to give a 1 Hz tick. Software can ask for a single timing correction through a small write-only configuration word. The correction changes the length of exactly one 256 Hz period by a signed number of source-clock periods, taken from a 5-bit trim code. Because the 1 Hz tick is derived from the corrected 256 Hz tick, every correction also moves the 1 Hz tick.

A positive correction lengthens a period, so the regulated clocks lose time. A negative correction shortens a period, so they gain time. Periodic trimming is done by software, which writes the trigger again at each interval it chooses.

A monitor pin can carry either regulated clock as a square wave, or it can be held low.

Top module: `clk_trim_divider`

## Requirements
- R1: After synchronous reset, the configuration fields are as follows: trim code 0x00, monitor select 0, monitor enable 0, and no correction pending. The outputs `tick_256`, `tick_1` and `mon_out` are low, and the first 256 Hz period starts at the first clock after reset is released.
- R2: Without a correction, `tick_256` is high for one source clock at the end of every period, and each period is 128 source clocks long.
- R3: Trim codes 0x00 to 0x0F select a correction n of +1 to +16 (n = code + 1). The corrected period lasts 128 + n source clocks.
- R4: Trim codes 0x10 to 0x1E select n = code − 31, which gives −15 to −1. Code 0x1F selects n = 0. The corrected period lasts 128 + n clocks, so no period is shorter than 113 clocks.
- R5: A configuration write with `cfg_wdata[5]` = 1 (the trigger) corrects exactly one 256 Hz period. All later periods are 128 clocks long until the trigger is written again.
- R6: Periods are numbered from 0 after reset. A pending request is applied to the next period whose number is a multiple of 4 (a 64 Hz boundary). It must be latched before that period starts. The pending request then clears.
- R7: A trigger write that arrives while a request is pending has no effect. Only one period is corrected.
- R8: The trim code is read when the correction is applied. A trim write without the trigger, made while a request is pending, sets the correction that is used.
- R9: `tick_1` pulses together with every 256th `tick_256` pulse. Consecutive `tick_1` pulses are 256 ticks apart.
- R10: `mon_out` is registered, so it shows the previous cycle's state. It is low while enable (`cfg_wdata[7]`) is 0. With enable 1 and select (`cfg_wdata[6]`) 0, it is high during the first 64 clocks of each 256 Hz period. With select 1, it is high during the first 128 ticks of each 1 Hz second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one clock |
| cfg_wdata | input | 8 | [4:0] trim code, [5] trigger, [6] monitor select, [7] monitor enable |
| tick_256 | output | 1 | One-clock pulse ending each regulated 256 Hz period |
| tick_1 | output | 1 | One-clock pulse ending each regulated second |
| mon_out | output | 1 | Monitor pin carrying the selected regulated clock, or low |

## Verification
The checker assumes that `cfg_we` is a single-cycle strobe driven synchronously to `clk`. It also assumes that reset lasts at least one edge, so that the period counter starts from a known phase. Its period-length bound holds only because the trim code is 5 bits and is decoded at one point, and the bench drives only legal 5-bit codes. Trigger writes are placed a fixed number of clocks after a known 64 Hz group boundary. This keeps every repeated trigger inside a single pending window, so the expected corrected period number is known in advance.

// File: rtl/clk_trim_pkg.sv
package clk_trim_pkg;

    localparam int DEF_SRC_PER_TICK  = 128;
    localparam int DEF_TRIM_W        = 5;
    localparam int DEF_GROUP_TICKS   = 4;
    localparam int DEF_TICKS_PER_SEC = 256;

    typedef enum logic {
        MON_FAST = 1'b0,
        MON_SLOW = 1'b1
    } mon_src_e;

    // Signed correction in source clocks for a trim code of the given width.
    // Codes with the top bit clear give +1 upward; codes with it set count
    // down from zero at the all-ones code.
    function automatic int trim_to_delta(input int unsigned code, input int width);
        int unsigned top;
        top = (code >> (width - 1)) & 1;
        if (top != 0)
            return int'(code) - ((1 << width) - 1);
        else
            return int'(code) + 1;
    endfunction

endpackage

// File: rtl/trim_cfg_regs.sv
module trim_cfg_regs
    import clk_trim_pkg::*;
#(
    parameter int TRIM_W = DEF_TRIM_W,
    localparam int CFG_W = TRIM_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              apply,
    output logic [TRIM_W-1:0] trim_q,
    output mon_src_e          mon_src,
    output logic              mon_en,
    output logic              pending
);

    logic trig_wr;
    assign trig_wr = cfg_we && cfg_wdata[TRIM_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q  <= '0;
            mon_src <= MON_FAST;
            mon_en  <= 1'b0;
        end else if (cfg_we) begin
            trim_q  <= cfg_wdata[TRIM_W-1:0];
            mon_src <= mon_src_e'(cfg_wdata[TRIM_W+1]);
            mon_en  <= cfg_wdata[TRIM_W+2];
        end
    end

    // A trigger seen while a request is outstanding is dropped.
    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (pending)
            pending <= !apply;
        else
            pending <= trig_wr;
    end

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
    import clk_trim_pkg::*;
#(
    parameter int SRC_PER_TICK = DEF_SRC_PER_TICK,
    parameter int TRIM_W       = DEF_TRIM_W,
    parameter int GROUP_TICKS  = DEF_GROUP_TICKS,
    localparam int PH_W        = $clog2(SRC_PER_TICK + (1 << (TRIM_W - 1)) + 1),
    localparam int GRP_W       = $clog2(GROUP_TICKS),
    localparam int HALF        = SRC_PER_TICK / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pending,
    input  logic [TRIM_W-1:0] trim_q,
    output logic              tick,
    output logic              apply,
    output logic              phase_hi
);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [PH_W-1:0]  len;
        logic [GRP_W-1:0] sub;
    } pre_state_t;

    pre_state_t st, st_n;
    logic [PH_W-1:0] len_base, len_corr;
    logic            last_in_group;

    assign len_base      = PH_W'(SRC_PER_TICK);
    assign len_corr      = PH_W'(SRC_PER_TICK + trim_to_delta(int'(trim_q), TRIM_W));
    assign tick          = (st.ph == st.len - PH_W'(1));
    assign last_in_group = (st.sub == GRP_W'(GROUP_TICKS - 1));
    assign apply         = tick && last_in_group && pending;
    assign phase_hi      = (st.ph < PH_W'(HALF));

    always_comb begin
        st_n = st;
        if (tick) begin
            st_n.ph  = '0;
            st_n.sub = last_in_group ? '0 : st.sub + 1'b1;
            st_n.len = apply ? len_corr : len_base;
        end else begin
            st_n.ph = st.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.ph  <= '0;
            st.len <= len_base;
            st.sub <= '0;
        end else begin
            st <= st_n;
        end
    end

endmodule

// File: rtl/sec_divider.sv
module sec_divider
    import clk_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = DEF_TICKS_PER_SEC,
    localparam int SEC_W        = $clog2(TICKS_PER_SEC)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic sec_tick,
    output logic sec_hi
);

    logic [SEC_W-1:0] cnt;
    logic             at_last;

    assign at_last  = (cnt == SEC_W'(TICKS_PER_SEC - 1));
    assign sec_tick = tick_in && at_last;
    assign sec_hi   = (cnt < SEC_W'(TICKS_PER_SEC / 2));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick_in)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/clk_trim_divider.sv
module clk_trim_divider
    import clk_trim_pkg::*;
#(
    parameter int SRC_PER_TICK  = DEF_SRC_PER_TICK,
    parameter int TRIM_W        = DEF_TRIM_W,
    parameter int GROUP_TICKS   = DEF_GROUP_TICKS,
    parameter int TICKS_PER_SEC = DEF_TICKS_PER_SEC,
    localparam int CFG_W        = TRIM_W + 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tick_256,
    output logic             tick_1,
    output logic             mon_out
);

    logic [TRIM_W-1:0] trim_q;
    mon_src_e          mon_src;
    logic              mon_en;
    logic              pending;
    logic              apply;
    logic              fast_hi;
    logic              slow_hi;
    logic              mon_next;

    trim_cfg_regs #(.TRIM_W(TRIM_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .apply     (apply),
        .trim_q    (trim_q),
        .mon_src   (mon_src),
        .mon_en    (mon_en),
        .pending   (pending)
    );

    trim_prescaler #(
        .SRC_PER_TICK (SRC_PER_TICK),
        .TRIM_W       (TRIM_W),
        .GROUP_TICKS  (GROUP_TICKS)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .pending  (pending),
        .trim_q   (trim_q),
        .tick     (tick_256),
        .apply    (apply),
        .phase_hi (fast_hi)
    );

    sec_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sec (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (tick_256),
        .sec_tick (tick_1),
        .sec_hi   (slow_hi)
    );

    always_comb begin
        mon_next = 1'b0;
        if (mon_en) begin
            case (mon_src)
                MON_FAST: mon_next = fast_hi;
                MON_SLOW: mon_next = slow_hi;
                default:  mon_next = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mon_out <= 1'b0;
        else
            mon_out <= mon_next;
    end

endmodule

// File: rtl/clk_trim_checker.sv
module clk_trim_checker #(
    parameter int SRC_PER_TICK = 128,
    parameter int TRIM_W       = 5,
    localparam int CFG_W       = TRIM_W + 3,
    localparam int LEN_LO      = SRC_PER_TICK - (1 << (TRIM_W - 1)) + 1,
    localparam int LEN_HI      = SRC_PER_TICK + (1 << (TRIM_W - 1))
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             tick_256,
    input logic             tick_1,
    input logic             mon_out,
    input logic             mon_en,
    input logic             pending,
    input logic             apply
);

    int since_tick;

    always_ff @(posedge clk) begin
        if (rst || tick_256)
            since_tick <= 0;
        else
            since_tick <= since_tick + 1;
    end

    // R3 / R4: every period length stays within the trim range
    p_period_bounds_r3: assert property (@(posedge clk) disable iff (rst)
        tick_256 |-> ((since_tick + 1 >= LEN_LO) && (since_tick + 1 <= LEN_HI)));

    // R9: the seconds pulse only coincides with a fast tick
    p_sec_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
        tick_1 |-> tick_256);

    // R10: monitor goes low one cycle after enable is clear
    p_mon_off_low_r10: assert property (@(posedge clk) disable iff (rst)
        !mon_en |=> !mon_out);

    // R6: an applied request is cleared on the next cycle
    p_pend_clears_r6: assert property (@(posedge clk) disable iff (rst)
        apply |=> !pending);

    // R7: a trigger while pending neither clears nor renews the request early
    p_trig_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (pending && !apply && cfg_we && cfg_wdata[TRIM_W]) |=> pending);

endmodule

bind clk_trim_divider clk_trim_checker #(
    .SRC_PER_TICK (SRC_PER_TICK),
    .TRIM_W       (TRIM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .tick_256  (tick_256),
    .tick_1    (tick_1),
    .mon_out   (mon_out),
    .mon_en    (mon_en),
    .pending   (pending),
    .apply     (apply)
);

// File: tb/tb_clk_trim_divider.sv
module tb_clk_trim_divider;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       tick_256, tick_1, mon_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";

    bit b_sel = 1'b0;
    bit b_en  = 1'b0;

    clk_trim_divider dut (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .tick_256 (tick_256), .tick_1 (tick_1), .mon_out (mon_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- reference model ----------------
    int m_pos, m_len, m_idx, m_sec;
    bit m_pend, m_sel, m_en, m_mon;
    int m_trim;

    function automatic int corr_of(int code);
        if (code == 31) return 0;
        if (code >= 16) return code - 31;
        return code + 1;
    endfunction

    function automatic bit m_tick();
        return (m_pos == m_len - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_len = BASE; m_idx = 0; m_sec = 0;
            m_pend = 0; m_sel = 0; m_en = 0; m_mon = 0; m_trim = 0;
        end else begin
            bit t, ap;
            t  = m_tick();
            ap = t && (m_idx == 3) && m_pend;
            m_mon = m_en && (m_sel ? (m_sec < 128) : (m_pos < 64));
            if (t) begin
                m_pos = 0;
                m_idx = (m_idx + 1) % 4;
                m_sec = (m_sec + 1) % 256;
                m_len = ap ? BASE + corr_of(m_trim) : BASE;
            end else begin
                m_pos++;
            end
            if (m_pend) m_pend = !ap;
            else        m_pend = cfg_we && cfg_wdata[5];
            if (cfg_we) begin
                m_trim = int'(cfg_wdata[4:0]);
                m_sel  = cfg_wdata[6];
                m_en   = cfg_wdata[7];
            end
        end
    end

    // ---------------- per-clock comparison and recording ----------------
    int cyc = 0;
    int last_tick_cyc = -1;
    int tick_no = 0;
    int iv_len[$];
    int iv_per[$];
    int sec_at[$];

    always @(negedge clk) begin
        if (!rst) begin
            bit et;
            et = m_tick();
            checks++;
            if (tick_256 !== et) begin
                errors++;
                $display("FAIL %s tick_256 actual=%0b expected=%0b cyc=%0d", cur_req, tick_256, et, cyc);
            end
            checks++;
            if (tick_1 !== (et && m_sec == 255)) begin
                errors++;
                $display("FAIL R9 tick_1 actual=%0b expected=%0b cyc=%0d", tick_1, et && m_sec == 255, cyc);
            end
            checks++;
            if (mon_out !== m_mon) begin
                errors++;
                $display("FAIL R10 mon_out actual=%0b expected=%0b cyc=%0d", mon_out, m_mon, cyc);
            end
            if (tick_256) begin
                iv_len.push_back(cyc - last_tick_cyc);
                iv_per.push_back(tick_no);
                last_tick_cyc = cyc;
                if (tick_1) sec_at.push_back(tick_no);
                tick_no++;
            end
            cyc++;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int code, input bit trig);
        cfg_we    = 1'b1;
        cfg_wdata = {b_en, b_sel, trig, 5'(code)};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (tick_256) seen++;
        end
    endtask

    // Return at the negedge where the last period of a group of four ends.
    task automatic sync_group();
        do @(negedge clk); while (!(tick_256 && m_idx == 3));
        @(negedge clk);
    endtask

    task automatic check_intervals(input int exp_len, input int exp_n, input string req);
        int n_corr = 0;
        foreach (iv_len[i]) begin
            if (iv_len[i] != BASE) begin
                n_corr++;
                check(iv_len[i] == exp_len, req, iv_len[i], exp_len);
                check(iv_per[i] % 4 == 0, "R6 corrected period number mod 4", iv_per[i] % 4, 0);
            end
        end
        check(n_corr == exp_n, {req, " corrected period count"}, n_corr, exp_n);
    endtask

    task automatic run_code(input int code, input string req);
        sync_group();
        repeat (4) @(negedge clk);
        iv_len.delete(); iv_per.delete();
        cfg_write(code, 1'b1);
        wait_ticks(14);
        check_intervals(BASE + corr_of(code), (code == 31) ? 0 : 1, req);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(tick_256 == 1'b0, "R1 tick_256 after reset", tick_256, 0);
        check(tick_1 == 1'b0, "R1 tick_1 after reset", tick_1, 0);
        check(mon_out == 1'b0, "R1 mon_out after reset", mon_out, 0);

        // R2: free-running periods
        wait_ticks(20);
        check_intervals(BASE, 0, "R2");

        // R1: reset trim code 0x00 gives +1 when triggered without a trim write
        sync_group();
        repeat (4) @(negedge clk);
        iv_len.delete(); iv_per.delete();
        cfg_we = 1'b1; cfg_wdata = 8'h20; @(negedge clk); cfg_we = 1'b0;
        wait_ticks(14);
        check_intervals(BASE + 1, 1, "R1 default trim");

        // R3, R4, R5, R6: code mapping, one-shot, boundary
        cur_req = "R3";
        run_code(5'h00, "R3 code 0x00");
        run_code(5'h0F, "R3 code 0x0F");
        run_code(5'h07, "R5 code 0x07 one-shot");
        cur_req = "R4";
        run_code(5'h10, "R4 code 0x10");
        run_code(5'h1E, "R4 code 0x1E");
        run_code(5'h1F, "R4 code 0x1F");

        // R7: repeated triggers during pending window
        cur_req = "R7";
        sync_group();
        repeat (4) @(negedge clk);
        iv_len.delete(); iv_per.delete();
        cfg_write(5'h03, 1'b1);
        repeat (100) @(negedge clk);
        cfg_write(5'h03, 1'b1);
        repeat (100) @(negedge clk);
        cfg_write(5'h03, 1'b1);
        wait_ticks(14);
        check_intervals(BASE + 4, 1, "R7");

        // R8: trim changed while pending
        cur_req = "R8";
        sync_group();
        repeat (4) @(negedge clk);
        iv_len.delete(); iv_per.delete();
        cfg_write(5'h01, 1'b1);
        repeat (100) @(negedge clk);
        cfg_write(5'h12, 1'b0);
        wait_ticks(14);
        check_intervals(BASE - 13, 1, "R8");

        // R10: fast monitor duty
        cur_req = "R10";
        b_en = 1'b1; b_sel = 1'b0;
        cfg_write(5'h1F, 1'b0);
        repeat (10) @(negedge clk);
        begin
            int hi = 0;
            for (int i = 0; i < BASE; i++) begin
                if (mon_out) hi++;
                @(negedge clk);
            end
            check(hi == 64, "R10 fast monitor high clocks per period", hi, 64);
        end
        // R10: disabled monitor is low
        b_en = 1'b0;
        cfg_write(5'h1F, 1'b0);
        repeat (2) @(negedge clk);
        begin
            int hi = 0;
            for (int i = 0; i < 300; i++) begin
                if (mon_out) hi++;
                @(negedge clk);
            end
            check(hi == 0, "R10 disabled monitor high clocks", hi, 0);
        end
        // R10 / R9: slow monitor and seconds spacing
        b_en = 1'b1; b_sel = 1'b1;
        cfg_write(5'h1F, 1'b0);
        sec_at.delete();
        begin
            int hi = 0;
            do @(negedge clk); while (!tick_1);
            @(negedge clk);
            for (int i = 0; i < BASE * 256; i++) begin
                if (mon_out) hi++;
                @(negedge clk);
            end
            check(hi == BASE * 128, "R10 slow monitor high clocks per second", hi, BASE * 128);
        end
        do @(negedge clk); while (sec_at.size() < 2);
        check(sec_at[1] - sec_at[0] == 256, "R9 ticks between second pulses",
              sec_at[1] - sec_at[0], 256);
        check(sec_at[0] % 256 == 255, "R9 second pulse on 256th tick", sec_at[0] % 256, 255);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule